// File: doc/BRIEF.md
# DRAM Parallel-Test Compression Control

This block is the device-side control of a by-one dynamic memory. It watches the row strobe, column strobe and write enable, all active low, on a synchronous clock. From the order in which they change it works out what kind of cycle each one is: a normal access, an early write, a read, a read-modify-write, a page-mode access, a refresh with the column strobe first, a refresh with only the row strobe, or a hidden refresh. From that it sets or clears a parallel-test flag.

In normal operation every address selects one stored bit. In parallel-test operation the array is treated as eight times narrower. A write sets all eight cells of an octet to the data-in bit. The octet is the set of cells whose addresses differ only in row bit AW-1, column bit AW-1 and column bit 0. A read returns one pass/fail bit: 1 when the eight cells agree and 0 when any of them differ.

The storage is a small behavioural array so that the block can be exercised on its own. Row bits AW-1 and ROW_LO-1..0 are kept, and so are column bits AW-1 and COL_LO-1..0. All other address bits alias. The data output is modelled as a value plus an output-enable bit instead of a tri-state pin.

Top module: `dram_tcomp`

## Requirements
- R1: A row-strobe fall that is sampled while the column strobe and write enable are both low sets test_mode on the next clock.
- R2: A row-strobe fall that is sampled while the column strobe is low and write enable is high clears test_mode. This covers the refresh part of a hidden refresh.
- R3: A row cycle with no column-strobe fall before the row strobe rises again clears test_mode when that rise is sampled.
- R4: The row address is captured at the row-strobe fall and the column address at the column-strobe fall. In normal mode each (row, column) pair reads back the last bit written to it.
- R5: In test mode a write stores the data-in bit into all eight cells of the octet. The octet is selected by varying row bit AW-1, column bit AW-1 and column bit 0.
- R6: In test mode a read drives dout to 1 when the eight octet cells are equal and to 0 when they differ. Row bit AW-1, column bit AW-1 and column bit 0 do not change the result.
- R7: When write enable is low at the column-strobe fall, the cycle is an early write: din is stored and dout_oe stays 0.
- R8: When write enable is high at the column-strobe fall, dout_oe is 1 from the next clock until the clock after the column strobe rises. This holds even while the row strobe cycles underneath (hidden refresh).
- R9: A write-enable fall during a read while the column strobe stays low stores din at the captured column. dout keeps the value already read.
- R10: Reset clears test_mode and dout_oe.
- R11: Several column-strobe cycles within one row-strobe low period (page mode) all use the row captured at the row-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data, or pass/fail in test mode |
| dout_oe | output | 1 | Output drive enable (0 = high impedance) |
| test_mode | output | 1 | Parallel-test flag |

## Verification
The hardest case to reach from the ports is a test-mode read whose octet is mixed. No single write can produce it, because every test-mode write fills the whole octet. The stimulus therefore fills an octet in test mode and leaves test mode with a refresh. It then changes one cell with a normal write and re-enters test mode before reading. A hidden refresh is driven with the column strobe held low across a second row-strobe fall, to show that test mode exits while the read data stays driven.

// File: rtl/dram_tcomp.sv
module dram_tcomp #(
  parameter int AW     = 11,
  parameter int ROW_LO = 3,
  parameter int COL_LO = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout,
  output logic          dout_oe,
  output logic          test_mode
);
  localparam int IW    = 2 + ROW_LO + COL_LO;
  localparam int DEPTH = 1 << IW;

  logic          ras_q, cas_q, we_q;
  logic          row_act, cas_seen, reading;
  logic [AW-1:0] row_q, col_q;
  logic          mem [DEPTH];
  logic [7:0]    sect;

  function automatic logic [IW-1:0] idx(input logic [AW-1:0] r, input logic [AW-1:0] c);
    return {r[AW-1], r[ROW_LO-1:0], c[AW-1], c[COL_LO-1:0]};
  endfunction

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n & ~ras_n & row_act;
  wire cas_rise = ~cas_q & cas_n;
  wire we_fall  = we_q & ~we_n & reading & ~cas_n;
  wire wr_go    = (cas_fall & ~we_n) | we_fall;
  wire [AW-1:0] wr_col = cas_fall ? addr : col_q;

  always_comb
    for (int s = 0; s < 8; s++)
      sect[s] = mem[idx({s[2], row_q[AW-2:0]}, {s[1], addr[AW-2:1], s[0]})];

  wire tm_bit = (&sect) | ~(|sect);
  wire rd_bit = test_mode ? tm_bit : mem[idx(row_q, addr)];

  always_ff @(posedge clk)
    if (wr_go) begin
      if (test_mode) begin
        for (int s = 0; s < 8; s++)
          mem[idx({s[2], row_q[AW-2:0]}, {s[1], wr_col[AW-2:1], s[0]})] <= din;
      end else begin
        mem[idx(row_q, wr_col)] <= din;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      we_q      <= 1'b1;
      row_act   <= 1'b0;
      cas_seen  <= 1'b0;
      reading   <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      dout      <= 1'b0;
      dout_oe   <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_fall) begin
        cas_seen <= 1'b0;
        if (!cas_n) begin
          test_mode <= ~we_n;
          row_act   <= 1'b0;
        end else begin
          row_q   <= addr;
          row_act <= 1'b1;
        end
      end
      if (ras_rise) begin
        if (row_act && !cas_seen) test_mode <= 1'b0;
        row_act <= 1'b0;
      end
      if (cas_fall) begin
        col_q    <= addr;
        cas_seen <= 1'b1;
        reading  <= we_n;
        dout_oe  <= we_n;
        if (we_n) dout <= rd_bit;
      end
      if (cas_rise) begin
        dout_oe <= 1'b0;
        reading <= 1'b0;
      end
    end

  p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && !we_n) |=> test_mode);
  p_cbr_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && !cas_n && we_n) |=> !test_mode);
  p_rasonly_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && row_act && !cas_seen) |=> !test_mode);
  p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_fall && !ras_rise) |=> $stable(test_mode));
  p_early_write_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && !we_n) |=> !dout_oe);
  p_read_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && we_n) |=> dout_oe);
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cas_rise |=> !dout_oe);
  p_rmw_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && !cas_rise) |=> $stable(dout));
endmodule

// File: tb/sim_dram_tcomp.sv
module sim_dram_tcomp;
  localparam int AW = 11;
  logic clk = 0, rst_n = 0, ras_n = 1, cas_n = 1, we_n = 1, din = 0;
  logic [AW-1:0] addr = '0;
  logic dout, dout_oe, test_mode;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_tcomp #(.AW(AW), .ROW_LO(3), .COL_LO(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .test_mode(test_mode));

  // {row, col, data}
  localparam logic [22:0] VEC [8] = '{
    {11'h001, 11'h002, 1'b1}, {11'h002, 11'h003, 1'b0},
    {11'h403, 11'h00A, 1'b1}, {11'h004, 11'h40F, 1'b1},
    {11'h007, 11'h001, 1'b0}, {11'h000, 11'h000, 1'b1},
    {11'h406, 11'h405, 1'b0}, {11'h003, 11'h00B, 1'b1}};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic d);
    addr = r; ras_n = 0; @(negedge clk);
    addr = c; din = d; we_n = 0; cas_n = 0; @(negedge clk);
    chk("R7 early write keeps output off", dout_oe, 1'b0);
    we_n = 1; cas_n = 1; ras_n = 1; @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] r, input logic [AW-1:0] c, output logic d, output logic oe);
    addr = r; ras_n = 0; we_n = 1; @(negedge clk);
    addr = c; cas_n = 0; @(negedge clk);
    d = dout; oe = dout_oe;
    cas_n = 1; ras_n = 1; @(negedge clk);
    chk("R8 output released after column strobe rise", dout_oe, 1'b0);
    @(negedge clk);
  endtask

  task automatic cbr(input logic w);
    cas_n = 0; we_n = w; @(negedge clk);
    ras_n = 0; @(negedge clk);
    ras_n = 1; cas_n = 1; we_n = 1; @(negedge clk); @(negedge clk);
  endtask

  task automatic ras_only(input logic [AW-1:0] r);
    addr = r; ras_n = 0; @(negedge clk);
    ras_n = 1; @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic d, oe;
    repeat (3) @(negedge clk);
    chk("R10 reset test_mode", test_mode, 1'b0);
    chk("R10 reset dout_oe", dout_oe, 1'b0);
    rst_n = 1; @(negedge clk);

    for (int i = 0; i < 8; i++) wr(VEC[i][22:12], VEC[i][11:1], VEC[i][0]);
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][22:12], VEC[i][11:1], d, oe);
      chk("R4 normal read data", d, VEC[i][0]);
      chk("R8 read drives output", oe, 1'b1);
    end

    // R11 page mode: write col C then read col 2 and col C in one row cycle
    addr = 11'h001; ras_n = 0; @(negedge clk);
    addr = 11'h00C; din = 1; we_n = 0; cas_n = 0; @(negedge clk);
    cas_n = 1; we_n = 1; @(negedge clk);
    addr = 11'h002; cas_n = 0; @(negedge clk);
    chk("R11 page read first column", dout, 1'b1);
    cas_n = 1; @(negedge clk);
    addr = 11'h00C; cas_n = 0; @(negedge clk);
    chk("R11 page read written column", dout, 1'b1);
    cas_n = 1; ras_n = 1; @(negedge clk); @(negedge clk);

    // R9 read-modify-write on (001,002) holding 1
    addr = 11'h001; ras_n = 0; @(negedge clk);
    addr = 11'h002; cas_n = 0; @(negedge clk);
    chk("R9 rmw read phase", dout, 1'b1);
    din = 0; we_n = 0; @(negedge clk);
    chk("R9 rmw output kept", dout, 1'b1);
    chk("R9 rmw output still driven", dout_oe, 1'b1);
    we_n = 1; cas_n = 1; ras_n = 1; @(negedge clk); @(negedge clk);
    rd(11'h001, 11'h002, d, oe);
    chk("R9 rmw stored new data", d, 1'b0);

    // Test mode
    cbr(1'b0);
    chk("R1 enter test mode", test_mode, 1'b1);
    wr(11'h005, 11'h006, 1'b1);
    rd(11'h405, 11'h407, d, oe);
    chk("R6 equal octet reads 1", d, 1'b1);
    cbr(1'b1);
    chk("R2 plain refresh exits", test_mode, 1'b0);
    rd(11'h405, 11'h407, d, oe);
    chk("R5 octet cell 7 written", d, 1'b1);
    rd(11'h005, 11'h407, d, oe);
    chk("R5 octet cell 3 written", d, 1'b1);
    wr(11'h405, 11'h007, 1'b0);
    cbr(1'b0);
    chk("R1 re-enter test mode", test_mode, 1'b1);
    rd(11'h005, 11'h006, d, oe);
    chk("R6 mixed octet reads 0", d, 1'b0);
    rd(11'h405, 11'h407, d, oe);
    chk("R6 sector bits ignored", d, 1'b0);
    ras_only(11'h005);
    chk("R3 row-only cycle exits", test_mode, 1'b0);
    rd(11'h405, 11'h007, d, oe);
    chk("R4 normal single cell 0", d, 1'b0);
    rd(11'h005, 11'h006, d, oe);
    chk("R4 normal neighbour 1", d, 1'b1);

    // Hidden refresh during a test-mode read
    cbr(1'b0);
    addr = 11'h005; ras_n = 0; @(negedge clk);
    addr = 11'h006; cas_n = 0; @(negedge clk);
    chk("R6 test read before hidden refresh", dout, 1'b0);
    ras_n = 1; @(negedge clk);
    ras_n = 0; @(negedge clk);
    chk("R2 hidden refresh exits", test_mode, 1'b0);
    chk("R8 output held in hidden refresh", dout_oe, 1'b1);
    chk("R8 data held in hidden refresh", dout, 1'b0);
    ras_n = 1; cas_n = 1; @(negedge clk);
    chk("R8 release after hidden refresh", dout_oe, 1'b0);
    @(negedge clk);

    cbr(1'b0);
    rst_n = 0; @(negedge clk);
    chk("R10 reset clears test mode", test_mode, 1'b0);
    rst_n = 1; @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule